// File: doc/BRIEF.md
# PLL Feedback Divider Ramp Controller

This controller moves the feedback divider of a PLL that is already running from its present value to a new value. It does this through the PLL's own dynamic ramp, so the PLL is never reset and never leaves lock. A request carries the wanted divider value. The current value is taken from the coefficient word that the PLL presents. If the two values are equal, the controller finishes at once and writes nothing.

If the values differ, the controller runs a fixed sequence. It loads the two step-size constants and enters slowdown mode. It writes the new divider into the coefficient word and then enables the ramp. It then polls the ramp-done indication, which reaches the block through a synchroniser. Each step waits for the next pulse on a one-microsecond tick input. Polling is bounded. Both slowdown mode and the ramp enable are always dropped together, whether the ramp completes or the poll limit runs out. The outcome is reported one cycle after they drop.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle. A requester holds `req_valid` and `req_ndiv` steady until it sees `req_ready` high at a clock edge, and that edge is the transfer. While a ramp is in flight the request waits and is not lost.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle. A request is taken only at an edge where both `req_valid` and `req_ready` are high.
- R2: A request whose divider equals bits 15:8 of `coeff_in` raises `fin` for one cycle after the accepting edge, with `fin_timeout` low. It causes no coefficient write, no step load and no change to `slowdown` or `ramp_en`.
- R3: A request whose divider differs from the current one loads `step_a` = 0x2B and `step_b` = 0x0B, pulses `step_load`, and raises `slowdown`. All of these happen on the accepting edge.
- R4: At the first tick edge after `slowdown` rises, `coeff_wr` pulses for one cycle. With it, `coeff_out` carries the new divider in bits 15:8. Bits 7:0 and 31:16 are copied from the `coeff_in` value captured when the request was accepted.
- R5: `ramp_en` rises at the first tick edge after the coefficient write, and it is high only while `slowdown` is high.
- R6: `ramp_done_raw` passes through a two-flop synchroniser. After enable, the synchronised value is sampled at every tick edge, and a high sample ends the ramp with success.
- R7: At most POLL_LIMIT samples are taken. If the last one is still low, the ramp ends with timeout.
- R8: On either outcome, `slowdown` and `ramp_en` fall on the same edge.
- R9: `fin` is a one-cycle pulse issued one cycle after `slowdown` and `ramp_en` fall. `fin_timeout` is 1 for a timeout and 0 for success.
- R10: After reset, `slowdown`, `ramp_en`, `coeff_wr`, `step_load` and `fin` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_ndiv | input | NW | Requested feedback divider |
| coeff_in | input | CW | Current coefficient word from the PLL |
| coeff_out | output | CW | Coefficient word to write |
| coeff_wr | output | 1 | One-cycle write strobe for `coeff_out` |
| step_a | output | STEP_W | Ramp step A value |
| step_b | output | STEP_W | Ramp step B value |
| step_load | output | 1 | One-cycle strobe to load both step values |
| slowdown | output | 1 | Slowdown mode control |
| ramp_en | output | 1 | Dynamic ramp enable |
| ramp_done_raw | input | 1 | Asynchronous ramp-done indication |
| fin | output | 1 | One-cycle completion pulse |
| fin_timeout | output | 1 | Outcome qualifier with `fin`: 1 = timeout |

## Verification
The bench builds the block with its default parameters: 8-bit divider at bit 8, a 32-bit coefficient word, a poll limit of 500 and two synchroniser stages. The tick comes every five clocks, so the full 500-poll timeout takes about 2,500 cycles and is reached in the run. Ramps that complete on the first poll and after a delay of several microseconds both fit in the same run. A request that repeats the value just written exercises the path where the divider is unchanged.

// File: rtl/ndiv_ramp_pkg.sv
package ndiv_ramp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_N,
    ST_WAIT_EN,
    ST_POLL,
    ST_REPORT
  } ramp_state_t;
endpackage

// File: rtl/ndiv_ramp_sync.sv
module ndiv_ramp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/ndiv_ramp_pollcnt.sv
module ndiv_ramp_pollcnt #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;

  assign last = (cnt == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/ndiv_ramp_ctrl.sv
module ndiv_ramp_ctrl
  import ndiv_ramp_pkg::*;
#(
  parameter int          NW          = 8,
  parameter int          N_LSB       = 8,
  parameter int          CW          = 32,
  parameter int          STEP_W      = 8,
  parameter logic [7:0]  STEP_A_VAL  = 8'h2B,
  parameter logic [7:0]  STEP_B_VAL  = 8'h0B,
  parameter int          POLL_LIMIT  = 500,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NW-1:0]     req_ndiv,
  input  logic [CW-1:0]     coeff_in,
  output logic [CW-1:0]     coeff_out,
  output logic              coeff_wr,
  output logic [STEP_W-1:0] step_a,
  output logic [STEP_W-1:0] step_b,
  output logic              step_load,
  output logic              slowdown,
  output logic              ramp_en,
  input  logic              ramp_done_raw,
  output logic              fin,
  output logic              fin_timeout
);
  ramp_state_t       st;
  logic [CW-1:0]     cap_word;
  logic [NW-1:0]     tgt;
  logic [CW-1:0]     new_word;
  logic              done_s;
  logic              poll_last;
  logic              to_flag;
  logic              same_n;

  ndiv_ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ramp_done_raw), .q(done_s)
  );

  ndiv_ramp_pollcnt #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .clr(st == ST_WAIT_EN),
    .inc(st == ST_POLL && tick_us && !done_s),
    .last(poll_last)
  );

  assign req_ready = (st == ST_IDLE);
  assign same_n    = (req_ndiv == coeff_in[N_LSB +: NW]);

  always_comb begin
    new_word = cap_word;
    new_word[N_LSB +: NW] = tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cap_word    <= '0;
      tgt         <= '0;
      coeff_out   <= '0;
      coeff_wr    <= 1'b0;
      step_a      <= '0;
      step_b      <= '0;
      step_load   <= 1'b0;
      slowdown    <= 1'b0;
      ramp_en     <= 1'b0;
      fin         <= 1'b0;
      fin_timeout <= 1'b0;
      to_flag     <= 1'b0;
    end else begin
      coeff_wr  <= 1'b0;
      step_load <= 1'b0;
      fin       <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (same_n) begin
              fin         <= 1'b1;
              fin_timeout <= 1'b0;
            end else begin
              cap_word  <= coeff_in;
              tgt       <= req_ndiv;
              step_a    <= STEP_W'(STEP_A_VAL);
              step_b    <= STEP_W'(STEP_B_VAL);
              step_load <= 1'b1;
              slowdown  <= 1'b1;
              st        <= ST_WAIT_N;
            end
          end
        end
        ST_WAIT_N: begin
          if (tick_us) begin
            coeff_out <= new_word;
            coeff_wr  <= 1'b1;
            st        <= ST_WAIT_EN;
          end
        end
        ST_WAIT_EN: begin
          if (tick_us) begin
            ramp_en <= 1'b1;
            st      <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (tick_us && (done_s || poll_last)) begin
            slowdown <= 1'b0;
            ramp_en  <= 1'b0;
            to_flag  <= !done_s;
            st       <= ST_REPORT;
          end
        end
        ST_REPORT: begin
          fin         <= 1'b1;
          fin_timeout <= to_flag;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ndiv_ramp_ctrl_chk.sv
module ndiv_ramp_ctrl_chk #(
  parameter int         STEP_W     = 8,
  parameter logic [7:0] STEP_A_VAL = 8'h2B,
  parameter logic [7:0] STEP_B_VAL = 8'h0B,
  parameter int         POLL_LIMIT = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_us,
  input logic              req_valid,
  input logic              req_ready,
  input logic              coeff_wr,
  input logic [STEP_W-1:0] step_a,
  input logic [STEP_W-1:0] step_b,
  input logic              slowdown,
  input logic              ramp_en,
  input logic              fin,
  input logic              fin_timeout
);
  localparam int PW = $clog2(POLL_LIMIT + 2);
  logic [PW-1:0] en_ticks;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 en_ticks <= '0;
    else if (!ramp_en)          en_ticks <= '0;
    else if (tick_us)           en_ticks <= en_ticks + 1'b1;

  p_accept_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready || fin));

  p_step_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slowdown) |-> (step_a == STEP_W'(STEP_A_VAL) && step_b == STEP_W'(STEP_B_VAL)));

  p_write_in_slowdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coeff_wr |-> (slowdown && !ramp_en));

  p_enable_needs_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> slowdown);

  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> (en_ticks < PW'(POLL_LIMIT)));

  p_clear_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slowdown) |-> $fell(ramp_en));

  p_report_after_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (!slowdown && !ramp_en));

  p_fin_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_timeout) |=> !fin);
endmodule

bind ndiv_ramp_ctrl ndiv_ramp_ctrl_chk #(
  .STEP_W(STEP_W), .STEP_A_VAL(STEP_A_VAL), .STEP_B_VAL(STEP_B_VAL), .POLL_LIMIT(POLL_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_valid(req_valid),
  .req_ready(req_ready), .coeff_wr(coeff_wr), .step_a(step_a), .step_b(step_b),
  .slowdown(slowdown), .ramp_en(ramp_en), .fin(fin), .fin_timeout(fin_timeout)
);

// File: tb/ndiv_ramp_ctrl_test.sv
`timescale 1ns/1ps
module ndiv_ramp_ctrl_test;
  localparam int LIMIT = 500;
  localparam int TICK_DIV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_ndiv = '0;
  logic [31:0] coeff_in = 32'h0015_2003;
  logic [31:0] coeff_out;
  logic coeff_wr, step_load, slowdown, ramp_en, fin, fin_timeout;
  logic [7:0] step_a, step_b;
  logic ramp_done_raw = 1'b0;

  int checks = 0;
  int errors = 0;
  int done_delay = 0;
  int done_cnt = 0;
  bit last_to;

  always #2 clk = ~clk;

  ndiv_ramp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_valid(req_valid),
    .req_ready(req_ready), .req_ndiv(req_ndiv), .coeff_in(coeff_in),
    .coeff_out(coeff_out), .coeff_wr(coeff_wr), .step_a(step_a), .step_b(step_b),
    .step_load(step_load), .slowdown(slowdown), .ramp_en(ramp_en),
    .ramp_done_raw(ramp_done_raw), .fin(fin), .fin_timeout(fin_timeout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int phase = 0;
  int polls = 0;
  bit m_to = 0, s1 = 0, s2 = 0, seen;
  logic [31:0] m_cap = '0, e_word = '0;
  logic [7:0] m_tgt = '0, e_sa = '0, e_sb = '0;
  bit e_slow = 0, e_en = 0, e_wr = 0, e_load = 0, e_fin = 0, e_to = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; polls = 0; s1 = 0; s2 = 0; m_to = 0;
      e_word = '0; e_sa = '0; e_sb = '0;
      e_slow = 0; e_en = 0; e_wr = 0; e_load = 0; e_fin = 0; e_to = 0;
    end else begin
      e_wr = 0; e_load = 0; e_fin = 0;
      seen = s2; s2 = s1; s1 = ramp_done_raw;
      case (phase)
        0: if (req_valid) begin
             if (req_ndiv == coeff_in[15:8]) begin e_fin = 1; e_to = 0; end
             else begin
               m_cap = coeff_in; m_tgt = req_ndiv;
               e_sa = 8'h2B; e_sb = 8'h0B; e_load = 1; e_slow = 1; phase = 1;
             end
           end
        1: if (tick_us) begin
             e_word = {m_cap[31:16], m_tgt, m_cap[7:0]}; e_wr = 1; phase = 2;
           end
        2: if (tick_us) begin e_en = 1; polls = 0; phase = 3; end
        3: if (tick_us) begin
             if (seen) begin e_slow = 0; e_en = 0; m_to = 0; phase = 4; end
             else begin
               polls++;
               if (polls == LIMIT) begin e_slow = 0; e_en = 0; m_to = 1; phase = 4; end
             end
           end
        default: begin e_fin = 1; e_to = m_to; phase = 0; end
      endcase
    end
  end

  // Per-cycle comparison
  always @(negedge clk) if (rst_n) begin
    chk("R1 req_ready", {31'd0, req_ready}, {31'd0, phase == 0});
    chk("R3 step_load/step_a/step_b", {15'd0, step_load, step_a, step_b}, {15'd0, e_load, e_sa, e_sb});
    chk("R4 coeff_wr", {31'd0, coeff_wr}, {31'd0, e_wr});
    chk("R4 coeff_out", coeff_out, e_word);
    chk("R5 R8 slowdown/ramp_en", {30'd0, slowdown, ramp_en}, {30'd0, e_slow, e_en});
    chk("R9 fin", {31'd0, fin}, {31'd0, e_fin});
    if (fin) chk("R6 R7 fin_timeout", {31'd0, fin_timeout}, {31'd0, e_to});
  end

  // Tick generator, PLL register model and ramp-done model
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick_us <= (tdiv == 0);
    if (coeff_wr) coeff_in <= coeff_out;
    if (!ramp_en) begin done_cnt = 0; ramp_done_raw <= 1'b0; end
    else begin
      if (done_delay >= 0 && done_cnt >= done_delay) ramp_done_raw <= 1'b1;
      done_cnt++;
    end
  end

  task automatic request(input logic [7:0] n);
    @(negedge clk);
    req_valid = 1'b1; req_ndiv = n;
    for (int i = 0; i < 100; i++) begin
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (fin) begin last_to = fin_timeout; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R10 reset outputs", {27'd0, slowdown, ramp_en, coeff_wr, step_load, fin}, 32'd0);

    done_delay = 35; last_to = 1;
    request(8'h40);
    chk("R6 delayed ramp success", {31'd0, last_to}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R4 divider field written, M/PL kept", coeff_in, 32'h0015_4003);

    last_to = 1;
    request(8'h40);
    chk("R2 unchanged divider success", {31'd0, last_to}, 32'd0);
    chk("R2 coefficient untouched", coeff_in, 32'h0015_4003);
    chk("R2 no slowdown", {31'd0, slowdown}, 32'd0);

    done_delay = 0; last_to = 1;
    request(8'h18);
    chk("R6 immediate ramp success", {31'd0, last_to}, 32'd0);

    done_delay = -1; last_to = 0;
    request(8'h90);
    chk("R7 never-done timeout", {31'd0, last_to}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 cleared after timeout", {30'd0, slowdown, ramp_en}, 32'd0);
    chk("R4 written before timeout", coeff_in, 32'h0015_9003);

    last_to = 1;
    request(8'h90);
    chk("R2 equal after timeout", {31'd0, last_to}, 32'd0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule